// File: doc/BRIEF.md
# Decimal-Capable Add/Subtract ALU

This block is the arithmetic core of an 8-bit accumulator processor. It adds with carry or subtracts with borrow, working either on plain binary bytes or on packed binary-coded decimal bytes. A decimal-mode input selects the number system and a subtract input selects the operation. The carry input acts as a borrow-not input for subtraction, so a subtract with carry-in 1 computes a plain difference.

In decimal mode the status flags copy the quirks of the processor this unit serves, not a clean BCD adder. For a decimal add, negative and overflow come from a partly corrected sum, taken after the low digit has been adjusted but before the high digit has been adjusted. Zero comes from the plain binary sum. For a decimal subtract, every flag comes from the binary difference, and only the result byte is digit-corrected.

The arithmetic itself is combinational. The result and the four flags are captured in output registers on each rising clock edge, so an operand set shown in one cycle appears at the outputs after the next edge. A synchronous active-high reset clears all outputs.

Top module: `bcd_alu`

## Requirements
- R1: With decimal mode 0 and subtract 0, the result is the low 8 bits of A + B + carry-in, and carry-out is bit 8 of that sum.
- R2: In a binary add, overflow is 1 exactly when A and B have equal bit 7 and the result's bit 7 differs from B's bit 7.
- R3: With decimal mode 0 and subtract 1, the result is the low 8 bits of A − B − 1 + carry-in, and carry-out is 1 exactly when that value is zero or positive.
- R4: In a binary subtract, overflow is 1 exactly when A's bit 7 differs from the result's bit 7 and also differs from B's bit 7.
- R5: In binary mode, negative equals bit 7 of the result, and zero is 1 exactly when the result byte is 0x00.
- R6: In a decimal add, the low digit sum (A low + B low + carry-in) is adjusted to (sum − 10) with bit 4 set when it is 10 or more. The high digits of A and B are then added on top to form an intermediate value. If the intermediate value exceeds 0x9F, 0x60 is added. The result is the low 8 bits of this corrected value.
- R7: In a decimal add, carry-out is 1 exactly when the corrected value of R6 exceeds 0xFF.
- R8: In a decimal add, negative is bit 7 of the intermediate value of R6 before the 0x60 step. Overflow applies the rule of R2 with that intermediate value in place of the result.
- R9: In a decimal add, zero is 1 exactly when the low 8 bits of the binary sum A + B + carry-in are 0x00.
- R10: In a decimal subtract, the low digit difference is A low − B low − 1 + carry-in and the high digit difference is A high − B high. If the low difference borrows (bit 4 set), 6 is subtracted from it and the high difference is decremented. If the high difference then borrows, 6 is subtracted from it. The result packs the corrected high digit in bits 7:4 and the corrected low digit in bits 3:0.
- R11: In a decimal subtract, carry-out, overflow, negative and zero are the values a binary subtract of the same inputs gives (R3, R4, R5).
- R12: All outputs are registered, and an input set is reflected at the outputs after one rising clock edge. While reset is high at an edge, every output becomes 0 whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on its rising edge |
| rst | input | 1 | Synchronous active-high reset; clears all outputs |
| acc_i | input | 8 | Accumulator operand A |
| opnd_i | input | 8 | Second operand B |
| carry_i | input | 1 | Carry-in (borrow-not when subtracting) |
| dec_i | input | 1 | 1 selects packed-BCD mode, 0 selects binary |
| sub_i | input | 1 | 1 selects subtract, 0 selects add |
| res_o | output | 8 | Registered result byte |
| carry_o | output | 1 | Registered carry-out |
| ovf_o | output | 1 | Registered overflow flag |
| neg_o | output | 1 | Registered negative flag |
| zero_o | output | 1 | Registered zero flag |

## Verification
On every cycle the assertions check properties that relate one cycle's inputs to the next cycle's outputs. In binary mode, negative follows the result's sign bit. Binary add overflow only appears with like-signed operands. Subtracting equal operands with no borrow gives a zero result with carry set. Decimal add and subtract of valid BCD operands give valid BCD digits. In decimal subtract, zero follows the binary difference. The quirks of R8 and R9 and the exact digit correction are only shown by the bench. It sweeps every accumulator value against a spread of operands, in all four modes and with both carry-in values, and compares each output against an arithmetic model, including directed cases where the decimal flags and the corrected result disagree.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DIG_W  = BYTE_W / 2;
  localparam int unsigned SUM_W  = BYTE_W + 1;
  localparam int unsigned DIFF_W = DIG_W + 2;

  typedef struct packed {
    logic [BYTE_W-1:0] res;
    logic              c;
    logic              v;
    logic              n;
    logic              z;
  } alu_flags_t;
endpackage

// File: rtl/bcd_alu_bin.sv
module bcd_alu_bin
  import bcd_alu_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  logic              cin,
  input  logic              sub,
  output alu_flags_t        flg
);
  logic [BYTE_W-1:0] b_eff;
  logic [SUM_W-1:0]  sum;
  logic              sa, sb, sr;

  always_comb begin
    b_eff   = sub ? ~b : b;
    sum     = {1'b0, a} + {1'b0, b_eff} + {{BYTE_W{1'b0}}, cin};
    sa      = a[BYTE_W-1];
    sb      = b_eff[BYTE_W-1];
    sr      = sum[BYTE_W-1];
    flg.res = sum[BYTE_W-1:0];
    flg.c   = sum[BYTE_W];
    flg.v   = (sa == sb) && (sr != sa);
    flg.n   = sr;
    flg.z   = (sum[BYTE_W-1:0] == '0);
  end
endmodule

// File: rtl/bcd_alu_dadd.sv
module bcd_alu_dadd
  import bcd_alu_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  logic              cin,
  output logic [BYTE_W-1:0] res,
  output logic              cout,
  output logic              ovf,
  output logic              neg
);
  localparam logic [DIG_W:0]    DIG_TEN  = (DIG_W+1)'(10);
  localparam logic [DIG_W:0]    DIG_FLAG = (DIG_W+1)'(1 << DIG_W);
  localparam logic [SUM_W-1:0]  HI_LIMIT = SUM_W'(9 << DIG_W) | SUM_W'((1 << DIG_W) - 1);
  localparam logic [SUM_W:0]    HI_FIX   = (SUM_W+1)'(6 << DIG_W);

  logic [DIG_W:0]   lo_sum, lo_adj;
  logic [SUM_W-1:0] mid;
  logic [SUM_W:0]   fixed;

  always_comb begin
    lo_sum = {1'b0, a[DIG_W-1:0]} + {1'b0, b[DIG_W-1:0]} + {{DIG_W{1'b0}}, cin};
    lo_adj = (lo_sum >= DIG_TEN) ? ((lo_sum - DIG_TEN) | DIG_FLAG) : lo_sum;
    mid    = SUM_W'(lo_adj)
           + {1'b0, a[BYTE_W-1:DIG_W], {DIG_W{1'b0}}}
           + {1'b0, b[BYTE_W-1:DIG_W], {DIG_W{1'b0}}};
    neg    = mid[BYTE_W-1];
    ovf    = (a[BYTE_W-1] == b[BYTE_W-1]) && (b[BYTE_W-1] != mid[BYTE_W-1]);
    fixed  = (mid > HI_LIMIT) ? ({1'b0, mid} + HI_FIX) : {1'b0, mid};
    cout   = (fixed[SUM_W:BYTE_W] != '0);
    res    = fixed[BYTE_W-1:0];
  end
endmodule

// File: rtl/bcd_alu_dsub.sv
module bcd_alu_dsub
  import bcd_alu_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  input  logic              cin,
  output logic [BYTE_W-1:0] res
);
  localparam logic [DIFF_W-1:0] SIX = DIFF_W'(6);
  localparam logic [DIFF_W-1:0] ONE = DIFF_W'(1);

  logic [DIFF_W-1:0] lo_d, hi_d, lo_c, hi_b, hi_c;

  always_comb begin
    lo_d = DIFF_W'(a[DIG_W-1:0]) - DIFF_W'(b[DIG_W-1:0]) - ONE + DIFF_W'(cin);
    hi_d = DIFF_W'(a[BYTE_W-1:DIG_W]) - DIFF_W'(b[BYTE_W-1:DIG_W]);
    if (lo_d[DIG_W]) begin
      lo_c = lo_d - SIX;
      hi_b = hi_d - ONE;
    end else begin
      lo_c = lo_d;
      hi_b = hi_d;
    end
    hi_c = hi_b[DIG_W] ? (hi_b - SIX) : hi_b;
    res  = {hi_c[DIG_W-1:0], lo_c[DIG_W-1:0]};
  end
endmodule

// File: rtl/bcd_alu.sv
module bcd_alu
  import bcd_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic [BYTE_W-1:0] opnd_i,
  input  logic              carry_i,
  input  logic              dec_i,
  input  logic              sub_i,
  output logic [BYTE_W-1:0] res_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              neg_o,
  output logic              zero_o
);
  alu_flags_t        bin_f, nxt, q;
  logic [BYTE_W-1:0] dadd_res, dsub_res;
  logic              dadd_c, dadd_v, dadd_n;

  bcd_alu_bin u_bin (
    .a(acc_i), .b(opnd_i), .cin(carry_i), .sub(sub_i), .flg(bin_f)
  );

  bcd_alu_dadd u_dadd (
    .a(acc_i), .b(opnd_i), .cin(carry_i),
    .res(dadd_res), .cout(dadd_c), .ovf(dadd_v), .neg(dadd_n)
  );

  bcd_alu_dsub u_dsub (
    .a(acc_i), .b(opnd_i), .cin(carry_i), .res(dsub_res)
  );

  always_comb begin
    nxt = bin_f;
    if (dec_i) begin
      if (sub_i) begin
        nxt.res = dsub_res;
      end else begin
        nxt.res = dadd_res;
        nxt.c   = dadd_c;
        nxt.v   = dadd_v;
        nxt.n   = dadd_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign res_o   = q.res;
  assign carry_o = q.c;
  assign ovf_o   = q.v;
  assign neg_o   = q.n;
  assign zero_o  = q.z;
endmodule

// File: rtl/bcd_alu_chk.sv
module bcd_alu_chk
  import bcd_alu_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [BYTE_W-1:0] acc_i,
  input logic [BYTE_W-1:0] opnd_i,
  input logic              carry_i,
  input logic              dec_i,
  input logic              sub_i,
  input logic [BYTE_W-1:0] res_o,
  input logic              carry_o,
  input logic              ovf_o,
  input logic              neg_o,
  input logic              zero_o
);
  function automatic logic bcd_ok(input logic [BYTE_W-1:0] x);
    return (x[DIG_W-1:0] <= DIG_W'(9)) && (x[BYTE_W-1:DIG_W] <= DIG_W'(9));
  endfunction

  // R5: binary mode negative follows result sign
  p_bin_neg_r5: assert property (@(posedge clk) disable iff (rst)
    !dec_i |=> (neg_o == res_o[BYTE_W-1]));

  // R2: binary add overflow only with like-signed operands and a sign flip
  p_add_ovf_r2: assert property (@(posedge clk) disable iff (rst)
    (!dec_i && !sub_i && (acc_i[BYTE_W-1] != opnd_i[BYTE_W-1])) |=> !ovf_o);

  // R3: equal operands with no borrow give zero with carry set
  p_sub_equal_r3: assert property (@(posedge clk) disable iff (rst)
    (!dec_i && sub_i && carry_i && (acc_i == opnd_i)) |=> (res_o == '0 && carry_o && zero_o));

  // R6: valid BCD operands give a valid BCD sum
  p_dadd_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (dec_i && !sub_i && bcd_ok(acc_i) && bcd_ok(opnd_i)) |=> bcd_ok(res_o));

  // R10: valid BCD operands give a valid BCD difference
  p_dsub_valid_r10: assert property (@(posedge clk) disable iff (rst)
    (dec_i && sub_i && bcd_ok(acc_i) && bcd_ok(opnd_i)) |=> bcd_ok(res_o));

  // R11: decimal subtract zero follows the binary difference
  p_dsub_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (dec_i && sub_i) |=> (zero_o ==
      (($past(acc_i) - $past(opnd_i) - BYTE_W'(!$past(carry_i))) == '0)));

  // R12: reset clears every output at the next edge
  p_reset_clear_r12: assert property (@(posedge clk)
    rst |=> (res_o == '0 && !carry_o && !ovf_o && !neg_o && !zero_o));
endmodule

bind bcd_alu bcd_alu_chk u_chk (
  .clk(clk), .rst(rst), .acc_i(acc_i), .opnd_i(opnd_i), .carry_i(carry_i),
  .dec_i(dec_i), .sub_i(sub_i), .res_o(res_o), .carry_o(carry_o),
  .ovf_o(ovf_o), .neg_o(neg_o), .zero_o(zero_o)
);

// File: tb/test_bcd_alu.sv
module test_bcd_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc_i = 8'h00, opnd_i = 8'h00;
  logic       carry_i = 1'b0, dec_i = 1'b0, sub_i = 1'b0;
  logic [7:0] res_o;
  logic       carry_o, ovf_o, neg_o, zero_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  bcd_alu i_bcd_alu (
    .clk(clk), .rst(rst), .acc_i(acc_i), .opnd_i(opnd_i), .carry_i(carry_i),
    .dec_i(dec_i), .sub_i(sub_i), .res_o(res_o), .carry_o(carry_o),
    .ovf_o(ovf_o), .neg_o(neg_o), .zero_o(zero_o)
  );

  // Reference: returns {res[7:0], c, v, n, z}
  function automatic logic [11:0] model(input int a, input int b, input int c,
                                        input bit d, input bit s);
    int r, co, v, n, z, t, lo, al, ah;
    if (!d && !s) begin
      t = a + b + c; r = t & 255; co = (t >> 8) & 1;
      v = (((a ^ b) & 128) == 0 && ((b ^ t) & 128) != 0) ? 1 : 0;
      n = (r >> 7) & 1; z = (r == 0) ? 1 : 0;
    end else if (!d && s) begin
      t = a - b - 1 + c; r = t & 255; co = (t >= 0) ? 1 : 0;
      v = (((a ^ t) & 128) != 0 && ((a ^ b) & 128) != 0) ? 1 : 0;
      n = (r >> 7) & 1; z = (r == 0) ? 1 : 0;
    end else if (d && !s) begin
      lo = (a & 15) + (b & 15) + c;
      if (lo >= 10) lo = (lo - 10) | 16;
      t = lo + (a & 240) + (b & 240);
      n = (t >> 7) & 1;
      z = (((a + b + c) & 255) == 0) ? 1 : 0;
      v = (((a ^ b) & 128) == 0 && ((b ^ t) & 128) != 0) ? 1 : 0;
      if (t > 159) t = t + 96;
      co = (t > 255) ? 1 : 0;
      r = t & 255;
    end else begin
      t = a - b - 1 + c; co = (t >= 0) ? 1 : 0;
      v = (((a ^ t) & 128) != 0 && ((a ^ b) & 128) != 0) ? 1 : 0;
      n = (t >> 7) & 1; z = ((t & 255) == 0) ? 1 : 0;
      al = (a & 15) - (b & 15) - 1 + c;
      ah = (a >> 4) - (b >> 4);
      if ((al & 16) != 0) begin al = al - 6; ah = ah - 1; end
      if ((ah & 16) != 0) ah = ah - 6;
      r = ((ah & 15) << 4) | (al & 15);
    end
    return {r[7:0], co[0], v[0], n[0], z[0]};
  endfunction

  function automatic string req_of(input bit d, input bit s, input int f);
    // f: 0 res, 1 carry, 2 ovf, 3 neg, 4 zero
    if (!d && !s) return (f == 0 || f == 1) ? "R1" : (f == 2) ? "R2" : "R5";
    if (!d && s)  return (f == 0 || f == 1) ? "R3" : (f == 2) ? "R4" : "R5";
    if (d && !s)  return (f == 0) ? "R6" : (f == 1) ? "R7" : (f == 4) ? "R9" : "R8";
    return (f == 0) ? "R10" : "R11";
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, compare.
  task automatic apply(input int a, input int b, input int c, input bit d, input bit s);
    logic [11:0] e;
    acc_i = 8'(a); opnd_i = 8'(b); carry_i = c[0]; dec_i = d; sub_i = s;
    e = model(a, b, c, d, s);
    @(negedge clk);
    check(req_of(d, s, 0), "result", res_o,   e[11:4]);
    check(req_of(d, s, 1), "carry",  carry_o, e[3]);
    check(req_of(d, s, 2), "ovf",    ovf_o,   e[2]);
    check(req_of(d, s, 3), "neg",    neg_o,   e[1]);
    check(req_of(d, s, 4), "zero",   zero_o,  e[0]);
  endtask

  task automatic check_cleared(input string what);
    check("R12", {what, " res"},   res_o,   0);
    check("R12", {what, " carry"}, carry_o, 0);
    check("R12", {what, " ovf"},   ovf_o,   0);
    check("R12", {what, " neg"},   neg_o,   0);
    check("R12", {what, " zero"},  zero_o,  0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_cleared("reset state");
    // R12: reset overrides live inputs
    acc_i = 8'hFF; opnd_i = 8'h01; carry_i = 1'b1;
    @(negedge clk);
    check_cleared("reset with inputs");
    rst = 1'b0;

    // Directed decimal quirks
    apply(8'h99, 8'h01, 0, 1, 0); // R6 R7 R8 R9: 0x00 carry, N from 0xA0, Z from 0x9A
    apply(8'h50, 8'h50, 0, 1, 0); // R8: intermediate 0xA0 sets N and V
    apply(8'h00, 8'h01, 1, 1, 1); // R10 R11: 0x99, flags from 0xFF
    apply(8'h00, 8'h99, 0, 1, 1); // R10: both digits borrow
    apply(8'h7F, 8'h01, 0, 0, 0); // R2: signed overflow
    apply(8'h80, 8'h01, 1, 0, 1); // R4: signed overflow on subtract
    apply(8'h00, 8'h00, 0, 0, 0); // R5: zero flag
    // R12: latency back-to-back with differing sets
    apply(8'h12, 8'h34, 1, 0, 0);
    apply(8'h12, 8'h34, 1, 1, 0);

    // Sweep: every A, operands at stride 5, all modes and carry-in values
    for (int md = 0; md < 4; md++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int a = 0; a < 256; a++) begin
          for (int b = 0; b < 256; b += 5) begin
            apply(a, b, ci, md[1], md[0]);
          end
        end
      end
    end

    // R12: mid-stream reset clears outputs
    rst = 1'b1;
    @(negedge clk);
    check_cleared("mid-stream reset");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule